// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in-first-out store held in a small array of registers. A stack pointer always selects the entry that is currently on top. A separate data register presents the value most recently taken off the stack. Two one-cycle strobes drive it: push stores a word and pop retrieves one. The FULL and EMPTY outputs tell the surrounding logic when either strobe would be refused.

The pointer is exactly log2(DEPTH) bits wide, so it wraps around at the depth. No occupancy counter exists. The flags are derived from the wrap alone:
- A push first advances the pointer, then writes at the new position. It raises FULL when the advanced pointer lands on zero.
- A pop first copies the top entry into the data register, then moves the pointer back. It raises EMPTY when the lowered pointer lands on zero.

Requests that the current flags forbid are dropped. When both strobes are raised together, the request is treated as a push only.

Top module: `lifo_stack`

## Requirements
- R1: After reset, EMPTY is 1, FULL is 0, the data register reads 0 and the pointer is zero.
- R2: Pops return words in the reverse order of the pushes that stored them (last in, first out).
- R3: FULL rises only on the accepted push that brings the pointer to zero, which is the DEPTH-th push counted from empty; it stays 0 after fewer pushes.
- R4: Every accepted push leaves EMPTY at 0 in the following cycle.
- R5: EMPTY rises only on the accepted pop that brings the pointer to zero, which is the pop that removes the last stored word.
- R6: Every accepted pop leaves FULL at 0 in the following cycle.
- R7: An accepted pop loads the top entry into the data register one clock later; in every other cycle, including pushes, the data register holds its value.
- R8: A push while FULL is 1 is ignored. The pointer, the flags and the stored words are unchanged, so later pops return the same words.
- R9: A pop while EMPTY is 1 is ignored. The data register and the flags keep their values.
- R10: When push and pop are both 1, the request acts as a push only. It is accepted unless FULL is 1, and the data register does not change.
- R11: FULL and EMPTY are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe, one word per cycle |
| pop_i | input | 1 | Pop strobe, one word per cycle |
| wdata_i | input | WIDTH | Word stored by an accepted push |
| rdata_o | output | WIDTH | Data register, the last popped word |
| full_o | output | 1 | All DEPTH entries hold data |
| empty_o | output | 1 | No entry holds data |

## Verification
The bench builds the stack with DEPTH=4 and WIDTH=8. With this depth, the pointer wraps to zero after only four pushes, so FULL is reached in a few cycles. This lets the table also cover refused pushes, a simultaneous request while full, a pop out of the full state and a drain back to EMPTY, all in one short run. Eight-bit words keep every stored value distinct, so a wrong entry index or a corrupted entry shows up directly in the popped value.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

    // Push wins over pop; a request refused by the flags becomes idle.
    function automatic stk_op_e decode_op(input logic push, input logic pop,
                                          input logic full, input logic empty);
        if (push) begin
            return full ? OP_IDLE : OP_PUSH;
        end
        if (pop) begin
            return empty ? OP_IDLE : OP_POP;
        end
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0] sel;

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign sel[i] = we_i && (waddr_i == AW'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) begin
                ent_q[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = ent_q[raddr_i];

endmodule

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op_i,
    output logic [PW-1:0] ptr_o,
    output logic          we_o,
    output logic [PW-1:0] waddr_o,
    output logic          full_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          full;
        logic          empty;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        we_o    = 1'b0;
        waddr_o = st_q.ptr + 1'b1;
        case (op_i)
            OP_PUSH: begin
                st_d.ptr   = st_q.ptr + 1'b1;
                we_o       = 1'b1;
                st_d.full  = (st_d.ptr == '0);
                st_d.empty = 1'b0;
            end
            OP_POP: begin
                st_d.ptr   = st_q.ptr - 1'b1;
                st_d.empty = (st_d.ptr == '0);
                st_d.full  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, full: 1'b0, empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o   = st_q.ptr;
    assign full_o  = st_q.full;
    assign empty_o = st_q.empty;

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
    import lifo_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o
);

    stk_op_e          op;
    logic [PW-1:0]    ptr;
    logic             we;
    logic [PW-1:0]    waddr;
    logic [WIDTH-1:0] top_word;
    logic [WIDTH-1:0] rd_d, rd_q;

    assign op = decode_op(push_i, pop_i, full_o, empty_o);

    lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .ptr_o   (ptr),
        .we_o    (we),
        .waddr_o (waddr),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    lifo_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata_i),
        .raddr_i (ptr),
        .rdata_o (top_word)
    );

    // Data register: loaded from the top entry before the pointer moves back.
    always_comb begin
        rd_d = rd_q;
        if (op == OP_POP) begin
            rd_d = top_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] rdata_o,
    input logic             full_o,
    input logic             empty_o
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o)); // R11

    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o) |=> !empty_o); // R4

    AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> !full_o); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && !push_i && !empty_o) |=> $stable(rdata_o)); // R7

    AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i) |=> (full_o && $stable(rdata_o))); // R8

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rdata_o))); // R9

    AST_FULL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(push_i)); // R3

    AST_EMPTY_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_o) |-> $past(pop_i && !push_i)); // R5

    AST_BOTH_IS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !full_o) |=> (!empty_o && $stable(rdata_o))); // R10

endmodule

bind lifo_stack lifo_stack_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .rdata_o (rdata_o),
    .full_o  (full_o),
    .empty_o (empty_o)
);

// File: tb/tb_lifo_stack.sv
`timescale 1ns/1ps
module tb_lifo_stack;

    localparam int W = 8;
    localparam int D = 4;
    localparam int NV = 17;

    typedef struct packed {
        logic         push;
        logic         pop;
        logic [W-1:0] data;
        logic [W-1:0] rd;
        logic         full;
        logic         empty;
    } vec_t;

    // Expected values hold after the single clock edge that follows each row.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0},  // push, R4
        '{1'b1, 1'b0, 8'h22, 8'h00, 1'b0, 1'b0},  // push, R7 hold
        '{1'b0, 1'b1, 8'h00, 8'h22, 1'b0, 1'b0},  // pop, R2
        '{1'b1, 1'b0, 8'h33, 8'h22, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'h44, 8'h22, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'h55, 8'h22, 1'b1, 1'b0},  // wrap to zero, R3
        '{1'b1, 1'b0, 8'h66, 8'h22, 1'b1, 1'b0},  // refused, R8
        '{1'b1, 1'b1, 8'h77, 8'h22, 1'b1, 1'b0},  // both while full, R10
        '{1'b0, 1'b1, 8'h00, 8'h55, 1'b0, 1'b0},  // pop out of full, R6
        '{1'b1, 1'b1, 8'h88, 8'h55, 1'b1, 1'b0},  // both, push only, R10
        '{1'b0, 1'b1, 8'h00, 8'h88, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h44, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h11, 1'b0, 1'b1},  // last word, R5
        '{1'b0, 1'b1, 8'h00, 8'h11, 1'b0, 1'b1},  // refused, R9
        '{1'b1, 1'b1, 8'h99, 8'h11, 1'b0, 1'b0},  // both while empty, R10
        '{1'b0, 1'b1, 8'h00, 8'h99, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0;
    logic         pop_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic         full_o;
    logic         empty_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lifo_stack #(.WIDTH(W), .DEPTH(D)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    task automatic check(input string req, input logic [W-1:0] rd,
                         input logic f, input logic e);
        checks++;
        if (rdata_o !== rd || full_o !== f || empty_o !== e) begin
            errors++;
            $display("FAIL %s: rdata=%h full=%b empty=%b, expected rdata=%h full=%b empty=%b",
                     req, rdata_o, full_o, empty_o, rd, f, e);
        end
    endtask

    task automatic step(input logic pu, input logic po, input logic [W-1:0] d);
        push_i  = pu;
        pop_i   = po;
        wdata_i = d;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 8'h00, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].push, VEC[i].pop, VEC[i].data);
            check($sformatf("R2/R3/R5/R7-R10 vector %0d", i),
                  VEC[i].rd, VEC[i].full, VEC[i].empty);
        end

        // R9: another pop on empty leaves data register and flags alone
        step(1'b0, 1'b1, 8'h00);
        check("R9 pop on empty", 8'h99, 1'b0, 1'b1);

        // R3: FULL only on the DEPTH-th push
        step(1'b1, 1'b0, 8'hA1);
        step(1'b1, 1'b0, 8'hA2);
        step(1'b1, 1'b0, 8'hA3);
        check("R3 not full after DEPTH-1 pushes", 8'h99, 1'b0, 1'b0);
        step(1'b1, 1'b0, 8'hA4);
        check("R3 full after DEPTH pushes", 8'h99, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'hEE);
        check("R8 push on full refused", 8'h99, 1'b1, 1'b0);

        // R2 / R8: drain in reverse order, refused word never appears
        step(1'b0, 1'b1, 8'h00);
        check("R2 R6 pop 1", 8'hA4, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00);
        check("R2 pop 2", 8'hA3, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00);
        check("R2 pop 3", 8'hA2, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00);
        check("R2 R5 pop 4", 8'hA1, 1'b0, 1'b1);

        // R1: reset in the middle of operation
        step(1'b1, 1'b0, 8'h5A);
        check("R4 push clears empty", 8'hA1, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 8'h00, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b0, 1'b1, 8'h00);
        check("R1 R9 stack empty after reset", 8'h00, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule